// File: doc/BRIEF.md
# Epoch Circuit Time-Window Allocator

This block is the central arbiter that shares circuit time among a group of memory controllers. Over each epoch every controller sends one statistics report: its reply arrival rate and its average output-buffer occupancy. Once every controller has reported, the block scores each one with a fixed two-term blend of the two statistics. It then splits a fixed repeating period of K cycles among the controllers in proportion to their scores. The score multiplies use Q0.8 coefficients. The split uses one shared sequential divider, which handles one controller per pass.

The finished set of window lengths is held internally until the next epoch starts. On the epoch-start pulse the set is driven onto the output bus together with a one-cycle valid strobe, so the routers can load it. Every window is at least one cycle long. The last controller takes the rounding residue, so the set always adds up to exactly K. When every score is zero, the period is shared out evenly.

Top module: `epoch_window_alloc`

## Requirements
- R1: After reset, winValid and calcDone are 0 and the window bus holds the even split. Each of the first k-1 windows is 1 + floor((K-k)/k) and the last window is the remainder; with the defaults (k=4, K=1000) every window is 250.
- R2: Each controller's score is S = 154·A + 102·B, where A is the arrival field and B the occupancy field of its most recent report. Each of the first k-1 windows is T_i = 1 + floor((K-k)·S_i / ΣS). Window i occupies winLen bits [i·W +: W], with W = clog2(K+1) (10 by default).
- R3: The last window equals K minus the sum of the others, so a broadcast set always adds up to exactly K.
- R4: Every broadcast window is at least 1, including the window of a controller whose score is zero.
- R5: When every score is zero, all scores are treated as 1 and ΣS as k, which gives the even split of R1.
- R6: A computation starts only after every controller has reported at least once since the previous start. A repeated report from the same controller replaces the earlier one. calcDone pulses high for exactly one cycle when all windows are computed.
- R7: An epoch-start pulse that arrives while the block is idle makes winValid high for one cycle, in the cycle after the pulse. At that point winLen shows the most recently completed set. winLen does not change in any cycle where winValid is low.
- R8: An epoch-start pulse that arrives while a computation is running is held. The broadcast then happens in the cycle after the calcDone pulse and carries the new set. An epoch start that lands in the cycle calcDone is high is broadcast in the next cycle.
- R9: A report that arrives in the cycle a computation starts, or while a computation is running, does not change that computation. It counts toward the following one, which starts by itself once every controller has reported again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| statValid | input | NUM_MC | Per-controller report strobe |
| statArrival | input | NUM_MC*STAT_W | Reply arrival rate; controller i in bits [i*STAT_W +: STAT_W] |
| statOccup | input | NUM_MC*STAT_W | Average buffer occupancy, packed like statArrival |
| epochStart | input | 1 | Start-of-epoch pulse that requests the broadcast |
| winLen | output | NUM_MC*WIN_W | Broadcast window lengths in cycles, controller i in bits [i*WIN_W +: WIN_W] |
| winValid | output | 1 | One-cycle strobe marking a broadcast |
| calcDone | output | 1 | One-cycle pulse when a new window set is ready |

## Verification
Two activities can fall in the same cycle. One is the epoch-start broadcast. The other is the end of a computation, or the start of the next one. The bench drives the epoch start several cycles into a divide, in the exact cycle where calcDone is seen, and in the cycle where a queued round starts by itself. It then checks that the broadcast carries the correct set: the fresh set in the first two cases, the set just finished in the third. Reports that arrive in the start cycle of a computation and during it are also checked: they must show up only in the round after.

// File: rtl/ewa_pkg.sv
package ewa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_STEP,
    ST_STORE,
    ST_LAST
  } ewaState_e;

  // strobes issued by the sequencer to the arithmetic side
  typedef struct packed {
    logic latchWeights;
    logic loadDiv;
    logic stepDiv;
    logic storeWin;
    logic storeLast;
    logic publish;
  } ewaStrobes_t;

endpackage

// File: rtl/ewa_control.sv
module ewa_control
  import ewa_pkg::*;
#(
  parameter int NUM_MC = 4,
  parameter int WIN_W  = 10,
  localparam int IDX_W = $clog2(NUM_MC),
  localparam int BIT_W = $clog2(WIN_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_MC-1:0] statValid,
  input  logic              epochStart,
  output ewaStrobes_t       strb,
  output logic [IDX_W-1:0]  idx,
  output logic [BIT_W-1:0]  bitIdx,
  output logic              calcDone
);

  ewaState_e         state;
  logic [NUM_MC-1:0] seen;
  logic              holdPub;
  logic              allSeen;

  assign allSeen = &seen;

  always_comb begin
    strb              = '0;
    strb.latchWeights = (state == ST_IDLE) && allSeen;
    strb.publish      = (state == ST_IDLE) && (epochStart || holdPub);
    strb.loadDiv      = (state == ST_LOAD);
    strb.stepDiv      = (state == ST_STEP);
    strb.storeWin     = (state == ST_STORE);
    strb.storeLast    = (state == ST_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      seen     <= '0;
      idx      <= '0;
      bitIdx   <= '0;
      holdPub  <= 1'b0;
      calcDone <= 1'b0;
    end else begin
      // a report landing in the launch cycle belongs to the next round
      seen     <= (strb.latchWeights ? '0 : seen) | statValid;
      calcDone <= (state == ST_LAST);
      if (strb.publish)   holdPub <= 1'b0;
      else if (epochStart) holdPub <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (strb.latchWeights) begin
            idx   <= '0;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          bitIdx <= BIT_W'(WIN_W - 1);
          state  <= ST_STEP;
        end
        ST_STEP: begin
          if (bitIdx == '0) state <= ST_STORE;
          else              bitIdx <= bitIdx - 1'b1;
        end
        ST_STORE: begin
          if (idx == IDX_W'(NUM_MC - 2)) begin
            state <= ST_LAST;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_LOAD;
          end
        end
        ST_LAST:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ewa_datapath.sv
module ewa_datapath
  import ewa_pkg::*;
#(
  parameter int NUM_MC = 4,
  parameter int STAT_W = 12,
  parameter int COEF_W = 8,
  parameter int ALPHA  = 154,
  parameter int GAMMA  = 102,
  parameter int PERIOD = 1000,
  parameter int WIN_W  = 10,
  localparam int IDX_W    = $clog2(NUM_MC),
  localparam int BIT_W    = $clog2(WIN_W),
  localparam int WEIGHT_W = STAT_W + COEF_W + 1,
  localparam int SUM_W    = WEIGHT_W + $clog2(NUM_MC),
  localparam int DIV_W    = SUM_W + WIN_W,
  localparam int SHARE    = PERIOD - NUM_MC
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_MC-1:0]        statValid,
  input  logic [NUM_MC*STAT_W-1:0] statArrival,
  input  logic [NUM_MC*STAT_W-1:0] statOccup,
  input  ewaStrobes_t              strb,
  input  logic [IDX_W-1:0]         idx,
  input  logic [BIT_W-1:0]         bitIdx,
  output logic [NUM_MC*WIN_W-1:0]  winLen,
  output logic                     winValid
);

  logic [STAT_W-1:0]   arrReg    [NUM_MC];
  logic [STAT_W-1:0]   occReg    [NUM_MC];
  logic [WEIGHT_W-1:0] rawWeight [NUM_MC];
  logic [WEIGHT_W-1:0] weight    [NUM_MC];
  logic [WIN_W-1:0]    pend      [NUM_MC];
  logic [WIN_W-1:0]    pub       [NUM_MC];
  logic [SUM_W-1:0]    rawTotal;
  logic [SUM_W-1:0]    total;
  logic                allZero;
  logic [DIV_W-1:0]    rem;
  logic [DIV_W-1:0]    divisorShift;
  logic [WIN_W-1:0]    quot;
  logic [WIN_W-1:0]    acc;
  logic [WIN_W-1:0]    quotPlusOne;

  function automatic logic [WIN_W-1:0] evenLen(input int i);
    int base;
    base = 1 + (PERIOD - NUM_MC) / NUM_MC;
    if (i == NUM_MC - 1) return WIN_W'(PERIOD - (NUM_MC - 1) * base);
    return WIN_W'(base);
  endfunction

  for (genvar g = 0; g < NUM_MC; g++) begin : g_mc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        arrReg[g] <= '0;
        occReg[g] <= '0;
      end else if (statValid[g]) begin
        arrReg[g] <= statArrival[g*STAT_W +: STAT_W];
        occReg[g] <= statOccup[g*STAT_W +: STAT_W];
      end
    end
    assign rawWeight[g] = WEIGHT_W'(ALPHA) * WEIGHT_W'(arrReg[g])
                        + WEIGHT_W'(GAMMA) * WEIGHT_W'(occReg[g]);
    assign winLen[g*WIN_W +: WIN_W] = pub[g];
  end

  always_comb begin
    rawTotal = '0;
    for (int i = 0; i < NUM_MC; i++) rawTotal += SUM_W'(rawWeight[i]);
  end

  assign allZero      = (rawTotal == '0);
  assign divisorShift = DIV_W'(total) << bitIdx;
  assign quotPlusOne  = quot + WIN_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MC; i++) begin
        weight[i] <= '0;
        pend[i]   <= evenLen(i);
        pub[i]    <= evenLen(i);
      end
      total    <= '0;
      rem      <= '0;
      quot     <= '0;
      acc      <= '0;
      winValid <= 1'b0;
    end else begin
      winValid <= strb.publish;
      if (strb.publish) begin
        for (int i = 0; i < NUM_MC; i++) pub[i] <= pend[i];
      end
      if (strb.latchWeights) begin
        for (int i = 0; i < NUM_MC; i++)
          weight[i] <= allZero ? WEIGHT_W'(1) : rawWeight[i];
        total <= allZero ? SUM_W'(NUM_MC) : rawTotal;
        acc   <= '0;
      end
      if (strb.loadDiv) begin
        rem  <= DIV_W'(SHARE) * DIV_W'(weight[idx]);
        quot <= '0;
      end
      if (strb.stepDiv && (rem >= divisorShift)) begin
        rem          <= rem - divisorShift;
        quot[bitIdx] <= 1'b1;
      end
      if (strb.storeWin) begin
        pend[idx] <= quotPlusOne;
        acc       <= acc + quotPlusOne;
      end
      if (strb.storeLast) begin
        pend[NUM_MC-1] <= WIN_W'(PERIOD) - acc;
      end
    end
  end

endmodule

// File: rtl/epoch_window_alloc.sv
module epoch_window_alloc
  import ewa_pkg::*;
#(
  parameter int NUM_MC = 4,
  parameter int STAT_W = 12,
  parameter int COEF_W = 8,
  parameter int ALPHA  = 154,
  parameter int GAMMA  = 102,
  parameter int PERIOD = 1000,
  localparam int WIN_W = $clog2(PERIOD + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_MC-1:0]        statValid,
  input  logic [NUM_MC*STAT_W-1:0] statArrival,
  input  logic [NUM_MC*STAT_W-1:0] statOccup,
  input  logic                     epochStart,
  output logic [NUM_MC*WIN_W-1:0]  winLen,
  output logic                     winValid,
  output logic                     calcDone
);

  localparam int IDX_W = $clog2(NUM_MC);
  localparam int BIT_W = $clog2(WIN_W);

  ewaStrobes_t       strb;
  logic [IDX_W-1:0]  idx;
  logic [BIT_W-1:0]  bitIdx;

  ewa_control #(
    .NUM_MC(NUM_MC),
    .WIN_W (WIN_W)
  ) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .statValid (statValid),
    .epochStart(epochStart),
    .strb      (strb),
    .idx       (idx),
    .bitIdx    (bitIdx),
    .calcDone  (calcDone)
  );

  ewa_datapath #(
    .NUM_MC(NUM_MC),
    .STAT_W(STAT_W),
    .COEF_W(COEF_W),
    .ALPHA (ALPHA),
    .GAMMA (GAMMA),
    .PERIOD(PERIOD),
    .WIN_W (WIN_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .statValid  (statValid),
    .statArrival(statArrival),
    .statOccup  (statOccup),
    .strb       (strb),
    .idx        (idx),
    .bitIdx     (bitIdx),
    .winLen     (winLen),
    .winValid   (winValid)
  );

endmodule

// File: rtl/ewa_checker.sv
module ewa_checker #(
  parameter int NUM_MC = 4,
  parameter int PERIOD = 1000,
  parameter int WIN_W  = 10
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    epochStart,
  input logic [NUM_MC*WIN_W-1:0] winLen,
  input logic                    winValid,
  input logic                    calcDone
);

  int   sumLen;
  logic noneZero;

  always_comb begin
    sumLen   = 0;
    noneZero = 1'b1;
    for (int i = 0; i < NUM_MC; i++) begin
      sumLen += int'(winLen[i*WIN_W +: WIN_W]);
      if (winLen[i*WIN_W +: WIN_W] == '0) noneZero = 1'b0;
    end
  end

  p_sum_exact_r3: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (sumLen == PERIOD));

  p_min_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> noneZero);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    calcDone |=> !calcDone);

  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !winValid |-> $stable(winLen));

  p_valid_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> ($past(epochStart) || $past(calcDone)));

endmodule

bind epoch_window_alloc ewa_checker #(
  .NUM_MC(NUM_MC),
  .PERIOD(PERIOD),
  .WIN_W (WIN_W)
) i_ewaChecker (
  .clk       (clk),
  .rstN      (rstN),
  .epochStart(epochStart),
  .winLen    (winLen),
  .winValid  (winValid),
  .calcDone  (calcDone)
);

// File: tb/test_epoch_window_alloc.sv
module test_epoch_window_alloc;

  localparam int NMC = 4;
  localparam int SW  = 12;
  localparam int WW  = 10;
  localparam int PER = 1000;

  typedef int unsigned vec_t [NMC];

  logic              clk = 1'b0;
  logic              rstN;
  logic [NMC-1:0]    statValid;
  logic [NMC*SW-1:0] statArrival;
  logic [NMC*SW-1:0] statOccup;
  logic              epochStart;
  logic [NMC*WW-1:0] winLen;
  logic              winValid;
  logic              calcDone;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  epoch_window_alloc i_epoch_window_alloc (
    .clk(clk), .rstN(rstN), .statValid(statValid), .statArrival(statArrival),
    .statOccup(statOccup), .epochStart(epochStart), .winLen(winLen),
    .winValid(winValid), .calcDone(calcDone)
  );

  function automatic vec_t expWin(vec_t a, vec_t b);
    vec_t   t;
    longint w [NMC];
    longint s = 0;
    longint acc = 0;
    for (int i = 0; i < NMC; i++) begin
      w[i] = 154 * longint'(a[i]) + 102 * longint'(b[i]);
      s += w[i];
    end
    if (s == 0) begin
      for (int i = 0; i < NMC; i++) w[i] = 1;
      s = NMC;
    end
    for (int i = 0; i < NMC - 1; i++) begin
      t[i] = int'(1 + ((PER - NMC) * w[i]) / s);
      acc += t[i];
    end
    t[NMC-1] = int'(PER - acc);
    return t;
  endfunction

  task automatic check(input int unsigned act, input int unsigned exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic checkWins(input vec_t e, input string tag);
    for (int i = 0; i < NMC; i++)
      check(winLen[i*WW +: WW], e[i], $sformatf("%s window %0d", tag, i));
  endtask

  task automatic setOne(input int i, input int unsigned a, input int unsigned b);
    statValid[i] = 1'b1;
    statArrival[i*SW +: SW] = SW'(a);
    statOccup[i*SW +: SW]   = SW'(b);
  endtask

  task automatic reportOne(input int i, input int unsigned a, input int unsigned b);
    @(negedge clk);
    setOne(i, a, b);
    @(negedge clk);
    statValid = '0;
  endtask

  task automatic reportAll(input vec_t a, input vec_t b);
    @(negedge clk);
    for (int i = 0; i < NMC; i++) setOne(i, a[i], b[i]);
    @(negedge clk);
    statValid = '0;
  endtask

  // returns at the negedge where calcDone is seen high
  task automatic waitDone(input bit quiet, input string tag);
    int n = 0;
    while (n < 2000) begin
      @(negedge clk);
      if (quiet) check(winValid, 0, {tag, " no broadcast while busy"});
      if (calcDone) return;
      n++;
    end
    check(0, 1, {tag, " calcDone timeout"});
  endtask

  task automatic pulseStart();
    @(negedge clk);
    epochStart = 1'b1;
    @(negedge clk);
    epochStart = 1'b0;
  endtask

  task automatic roundTrip(input vec_t a, input vec_t b, input string tag);
    vec_t e;
    e = expWin(a, b);
    reportAll(a, b);
    waitDone(0, tag);
    pulseStart();
    check(winValid, 1, {tag, " R7 strobe"});
    checkWins(e, tag);
    @(negedge clk);
    check(winValid, 0, {tag, " R7 strobe one cycle"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t a, b, e, prev, x, y;
    int unsigned seedDummy;
    seedDummy = $urandom(32'd2024);
    rstN = 1'b0; statValid = '0; statArrival = '0; statOccup = '0; epochStart = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(winValid, 0, "R1 winValid after reset");
    check(calcDone, 0, "R1 calcDone after reset");
    checkWins('{250, 250, 250, 250}, "R1 reset");

    // R2 R3 directed proportional split
    a = '{100, 200, 300, 400}; b = '{50, 0, 900, 10};
    e = expWin(a, b);
    reportAll(a, b);
    waitDone(0, "R2");
    check(winValid, 0, "R7 no strobe before start");
    checkWins('{250, 250, 250, 250}, "R7 bus held before start");
    pulseStart();
    check(winValid, 1, "R2 strobe");
    checkWins(e, "R2 R3 directed");
    prev = e;

    // R7 a second start republishes the same set
    pulseStart();
    check(winValid, 1, "R7 repeat strobe");
    checkWins(prev, "R7 repeat");

    // R5 all zero scores
    roundTrip('{0, 0, 0, 0}, '{0, 0, 0, 0}, "R5 zero");

    // R4 one dominant controller, others zero
    roundTrip('{4095, 0, 0, 0}, '{4095, 0, 0, 0}, "R4 dominant");
    roundTrip('{0, 0, 0, 4095}, '{0, 0, 0, 4095}, "R4 last dominant");

    // R6 latest report wins, no launch before every controller reported
    reportOne(0, 10, 10);
    reportOne(1, 20, 20);
    reportOne(2, 4000, 4000);
    reportOne(2, 30, 30);
    begin
      int seenDone = 0;
      repeat (80) begin
        @(negedge clk);
        if (calcDone) seenDone = 1;
      end
      check(seenDone, 0, "R6 no launch with one controller missing");
    end
    reportOne(3, 40, 40);
    waitDone(0, "R6");
    @(negedge clk);
    check(calcDone, 0, "R6 calcDone single cycle");
    pulseStart();
    checkWins(expWin('{10, 20, 30, 40}, '{10, 20, 30, 40}), "R6 latest report");

    // R8 start during computation is held
    x = '{700, 30, 5, 1200}; y = '{3, 3000, 80, 0};
    e = expWin(x, y);
    reportAll(x, y);
    @(negedge clk);
    epochStart = 1'b1;
    @(negedge clk);
    epochStart = 1'b0;
    check(winValid, 0, "R8 held while busy");
    waitDone(1, "R8");
    check(winValid, 0, "R8 no strobe in done cycle");
    @(negedge clk);
    check(winValid, 1, "R8 strobe after done");
    checkWins(e, "R8 held broadcast");

    // R8 start landing in the calcDone cycle
    x = '{1, 2, 3, 4}; y = '{4000, 3000, 2000, 1000};
    e = expWin(x, y);
    reportAll(x, y);
    waitDone(1, "R8 coincide");
    epochStart = 1'b1;
    @(negedge clk);
    epochStart = 1'b0;
    check(winValid, 1, "R8 coincide strobe");
    checkWins(e, "R8 coincide");

    // R9 reports in the launch cycle and during a computation
    x = '{500, 500, 500, 500}; y = '{0, 100, 200, 300};
    @(negedge clk);
    for (int i = 0; i < NMC; i++) setOne(i, x[i], y[i]);
    @(negedge clk);
    statValid = '0;
    setOne(0, 9, 4000);
    @(negedge clk);
    statValid = '0;
    reportOne(1, 3000, 1);
    reportOne(2, 0, 0);
    reportOne(3, 77, 66);
    waitDone(0, "R9 first");
    epochStart = 1'b1;
    @(negedge clk);
    epochStart = 1'b0;
    check(winValid, 1, "R9 strobe first round");
    checkWins(expWin(x, y), "R9 first round");
    waitDone(0, "R9 second");
    pulseStart();
    checkWins(expWin('{9, 3000, 0, 77}, '{4000, 1, 0, 66}), "R9 second round");

    // R2 R3 R4 random rounds
    for (int r = 0; r < 14; r++) begin
      for (int i = 0; i < NMC; i++) begin
        if ($urandom_range(0, 3) == 0) begin
          a[i] = 0; b[i] = 0;
        end else begin
          a[i] = $urandom_range(0, 4095);
          b[i] = $urandom_range(0, 4095);
        end
      end
      roundTrip(a, b, $sformatf("R2 R3 R4 random %0d", r));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule